// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block reads a 4x4 matrix keypad. It raises one column line at a time and reads the four row lines back. The row lines have pull-downs, so a row reads 1 only while a key at the crossing of that row and the active column is closed. A single clock-enable tick, made by dividing the system clock, sets the pace of all scanning and debouncing. No derived clock is used. The rows first pass through a synchronizer. The scanner then spends a set number of ticks on each column. When it sees any row high, it stops on that column and checks that the same row pattern stays put for the hold time before it reports the key.

A report is a one-cycle `key_valid_o` pulse. With it, `key_code_o` carries the hexadecimal code of the key, and that code stays on the port until the next report. Because the valid flag is separate, key 0 can be told apart from no key at all. After a report the scanner stays on the same column until every row has read 0 for the hold time. This prevents auto-repeat and also debounces the release. Scanning then picks up again from that same column.

Top module: `keymat_scanner`

## Requirements
- R1: Exactly one bit of `col_o` is 1 in every cycle (active-high column drive). Out of reset `col_o` is 4'b0001 (column 0, leftmost).
- R2: While no row reads 1, the active column steps through bit 0, 1, 2, 3, then back to 0. Each column stays active for DWELL_TICKS ticks, which is DWELL_TICKS*TICK_DIV clock cycles.
- R3: The internal tick fires once every TICK_DIV clock cycles. `col_o` and the scan state change only in the cycle that follows a tick.
- R4: A key is reported only after its synchronized row pattern has read the same value on HOLD_TICKS consecutive ticks. A press that is seen on fewer ticks produces no report.
- R5: Bit r of `row_i` is row r counted from the top, and bit c of `col_o` is column c counted from the left. Rows 0 to 2 in columns 0 to 2 encode to 3*r+c+1, which gives 1 to 9. Column 3 encodes to 0xA+r, which gives A, B, C and D.
- R6: In row 3, column 0 (the * key) encodes to 0xE, column 1 to 0x0 and column 2 (the # key) to 0xF. Key 0 is still reported with a `key_valid_o` pulse.
- R7: `key_valid_o` is high for exactly one cycle per press. `key_code_o` changes only in a cycle where `key_valid_o` is 1, and both outputs are 0 after reset.
- R8: After a report, the same column stays active until all rows have read 0 on HOLD_TICKS consecutive ticks. A key held down gives exactly one report, and a release shorter than the hold time gives no new report.
- R9: After a confirmed release, scanning picks up again on the same column and then moves on to the next column in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_i | input | 4 | Row lines from the keypad, pulled down, bit 0 = top row |
| col_o | output | 4 | One-hot active-high column drive, bit 0 = left column |
| key_code_o | output | 4 | Hexadecimal code of the most recently reported key |
| key_valid_o | output | 1 | One-cycle pulse marking a new key report |

## Verification
The embedded assertions check, on every cycle, the properties that do not depend on the stimulus. These are that the column drive is one-hot, that it moves only on a tick and only to the next column, that it stays parked while a key is held, that the valid pulse lasts one cycle, and that the code changes only together with that pulse. Other behaviour depends on the scenario, so only the bench can show it. This covers the full mapping from row and column to code across all sixteen keys, the exact dwell time per column, the rejection of a bouncing press that never holds for the full hold time, the single report for a long press, and the return to the parked column after a release.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

  localparam int unsigned KM_LINES = 4;

  typedef enum logic [1:0] {
    ST_SCAN,
    ST_CONFIRM,
    ST_HELD
  } km_state_e;

  // Key code from row index (0 = top) and column index (0 = left).
  function automatic logic [3:0] km_code(input logic [1:0] r, input logic [1:0] c);
    logic [3:0] rw;
    logic [3:0] cw;
    rw = {2'b00, r};
    cw = {2'b00, c};
    if (c == 2'd3) begin
      km_code = 4'hA + rw;
    end else if (r != 2'd3) begin
      km_code = rw * 4'd3 + cw + 4'd1;
    end else begin
      case (c)
        2'd0:    km_code = 4'hE;
        2'd1:    km_code = 4'h0;
        default: km_code = 4'hF;
      endcase
    end
  endfunction

endpackage

// File: rtl/keymat_tick.sv
module keymat_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R3: with a divider of two or more, ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/keymat_sync.sv
module keymat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/keymat_ctrl.sv
module keymat_ctrl
  import keymat_pkg::*;
#(
  parameter int unsigned DWELL_TICKS = 2,
  parameter int unsigned HOLD_TICKS  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [KM_LINES-1:0] rows_i,
  output logic [KM_LINES-1:0] col_oh_o,
  output logic [1:0]          col_idx_o,
  output logic [KM_LINES-1:0] snap_o,
  output logic                report_o
);
  localparam int unsigned DW = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
  localparam int unsigned HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

  km_state_e     st;
  logic [DW-1:0] dwell;
  logic [HW-1:0] hcnt;
  logic          dwell_done;
  logic          hold_done;
  logic          rows_idle;

  assign dwell_done = (dwell == DW'(DWELL_TICKS - 1));
  assign hold_done  = (hcnt == HW'(HOLD_TICKS - 1));
  assign rows_idle  = (rows_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_SCAN;
      dwell     <= '0;
      hcnt      <= '0;
      col_oh_o  <= 4'b0001;
      col_idx_o <= 2'd0;
      snap_o    <= '0;
      report_o  <= 1'b0;
    end else begin
      report_o <= 1'b0;
      if (tick_i) begin
        case (st)
          ST_SCAN: begin
            if (!rows_idle) begin
              snap_o <= rows_i;
              hcnt   <= HW'(1);
              st     <= ST_CONFIRM;
            end else if (dwell_done) begin
              dwell     <= '0;
              col_oh_o  <= {col_oh_o[2:0], col_oh_o[3]};
              col_idx_o <= col_idx_o + 2'd1;
            end else begin
              dwell <= dwell + 1'b1;
            end
          end
          ST_CONFIRM: begin
            if (rows_i == snap_o) begin
              if (hold_done) begin
                report_o <= 1'b1;
                hcnt     <= '0;
                st       <= ST_HELD;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end else begin
              dwell <= '0;
              st    <= ST_SCAN;
            end
          end
          ST_HELD: begin
            if (rows_idle) begin
              if (hold_done) begin
                hcnt  <= '0;
                dwell <= '0;
                st    <= ST_SCAN;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end else begin
              hcnt <= '0;
            end
          end
          default: st <= ST_SCAN;
        endcase
      end
    end
  end

  // R1: exactly one column driven
  p_col_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(col_oh_o) == 1);

  // R3: column only moves after a tick
  p_col_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(col_oh_o));

  // R2: a column change is always a step to the next column
  p_col_rotate_r2: assert property (@(posedge clk) disable iff (rst)
    (col_oh_o != $past(col_oh_o)) |-> (col_oh_o == $past({col_oh_o[2:0], col_oh_o[3]})));

  // R8: column parked while a key is held
  p_held_parks_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HELD) |=> $stable(col_oh_o));

  // R4: a report follows only a confirmation phase
  p_report_confirmed_r4: assert property (@(posedge clk) disable iff (rst)
    report_o |-> ($past(st) == ST_CONFIRM));

endmodule

// File: rtl/keymat_encode.sv
module keymat_encode
  import keymat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                report_i,
  input  logic [KM_LINES-1:0] snap_i,
  input  logic [1:0]          col_idx_i,
  output logic [3:0]          code_o,
  output logic                valid_o
);
  logic [1:0] ridx;

  always_comb begin
    ridx = 2'd0;
    for (int i = KM_LINES - 1; i >= 0; i--) begin
      if (snap_i[i]) ridx = 2'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= 4'h0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= report_i;
      if (report_i) code_o <= km_code(ridx, col_idx_i);
    end
  end

  // R7: one-cycle valid pulse
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R7: code only changes together with a valid pulse
  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(code_o));

endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner
  import keymat_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned DWELL_TICKS = 2,
  parameter int unsigned HOLD_TICKS  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] row_i,
  output logic [3:0] col_o,
  output logic [3:0] key_code_o,
  output logic       key_valid_o
);
  // TICK_DIV must exceed SYNC_STAGES so the rows of a new column settle
  // before the next tick samples them; HOLD_TICKS must be at least 2.
  logic                tick;
  logic [KM_LINES-1:0] rows_s;
  logic [1:0]          col_idx;
  logic [KM_LINES-1:0] snap;
  logic                report;

  keymat_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  keymat_sync #(.WIDTH(KM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (row_i),
    .q_o (rows_s)
  );

  keymat_ctrl #(.DWELL_TICKS(DWELL_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .rows_i    (rows_s),
    .col_oh_o  (col_o),
    .col_idx_o (col_idx),
    .snap_o    (snap),
    .report_o  (report)
  );

  keymat_encode u_enc (
    .clk       (clk),
    .rst       (rst),
    .report_i  (report),
    .snap_i    (snap),
    .col_idx_i (col_idx),
    .code_o    (key_code_o),
    .valid_o   (key_valid_o)
  );

endmodule

// File: tb/keymat_scanner_tb.sv
module keymat_scanner_tb;
  localparam int TDIV  = 4;
  localparam int DWELL = 3;
  localparam int HOLD  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_drv;
  logic [3:0] col_o;
  logic [3:0] key_code_o;
  logic       key_valid_o;

  logic       pressed = 1'b0;
  int         key_r = 0;
  int         key_c = 0;
  int         checks = 0;
  int         errors = 0;
  int         pulses = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    row_drv = 4'b0000;
    if (pressed && col_o[key_c]) row_drv = 4'b0001 << key_r;
  end

  keymat_scanner #(.TICK_DIV(TDIV), .DWELL_TICKS(DWELL), .HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .row_i       (row_drv),
    .col_o       (col_o),
    .key_code_o  (key_code_o),
    .key_valid_o (key_valid_o)
  );

  always @(negedge clk) if (!rst && key_valid_o) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int r, input int c);
    if (c == 3) return 10 + r;
    if (r < 3) return 3 * r + c + 1;
    if (c == 0) return 14;
    if (c == 1) return 0;
    return 15;
  endfunction

  task automatic wait_pulse(input int start, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (pulses > start) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    int         run;
    int         seen;
    int         start;
    repeat (3) @(negedge clk);
    check(col_o == 4'b0001, "R1 reset column", col_o, 1);
    check(key_valid_o == 1'b0, "R7 reset valid", key_valid_o, 0);
    check(key_code_o == 4'h0, "R7 reset code", key_code_o, 0);
    rst = 1'b0;

    // R2: stepping order and dwell with no key
    prev = col_o; run = 0; seen = 0;
    for (int i = 0; i < 400 && seen < 8; i++) begin
      @(negedge clk);
      run++;
      if (col_o != prev) begin
        check(col_o == {prev[2:0], prev[3]}, "R2 step order", col_o, {prev[2:0], prev[3]});
        if (seen > 0) check(run == DWELL * TDIV, "R2 dwell cycles", run, DWELL * TDIV);
        seen++; run = 0; prev = col_o;
      end
    end
    check(seen == 8, "R2 column changes", seen, 8);

    // R5/R6/R7/R8: sweep every key
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        string tag;
        tag = (r == 3 && c != 3) ? "R6" : "R5";
        key_r = r; key_c = c;
        start = pulses;
        pressed = 1'b1;
        wait_pulse(start, 400);
        check(pulses == start + 1, {tag, " press reported"}, pulses - start, 1);
        check(key_code_o == 4'(exp_code(r, c)), {tag, " code"}, key_code_o, exp_code(r, c));
        @(negedge clk);
        check(key_valid_o == 1'b0, "R7 single-cycle valid", key_valid_o, 0);
        repeat (150) @(negedge clk);
        check(pulses == start + 1, "R8 no auto-repeat", pulses - start, 1);
        pressed = 1'b0;
        repeat (100) @(negedge clk);
        check(pulses == start + 1, "R8 release no report", pulses - start, 1);
        check(key_code_o == 4'(exp_code(r, c)), "R7 code held", key_code_o, exp_code(r, c));
      end
    end

    // R4: bouncing press on key 9 never reaches the hold time
    key_r = 2; key_c = 2;
    start = pulses;
    for (int i = 0; i < 25; i++) begin
      pressed = 1'b1; repeat (8) @(negedge clk);
      pressed = 1'b0; repeat (8) @(negedge clk);
    end
    check(pulses == start, "R4 bounce rejected", pulses - start, 0);
    pressed = 1'b1;
    wait_pulse(start, 400);
    check(pulses == start + 1, "R4 steady press reported", pulses - start, 1);
    check(key_code_o == 4'h9, "R4 steady code", key_code_o, 9);
    pressed = 1'b0;
    repeat (100) @(negedge clk);

    // R8/R9: short release while parked, then full release
    key_r = 1; key_c = 1;
    start = pulses;
    pressed = 1'b1;
    wait_pulse(start, 400);
    check(key_code_o == 4'h5, "R5 key 5 code", key_code_o, 5);
    repeat (40) @(negedge clk);
    pressed = 1'b0; repeat (6) @(negedge clk);
    pressed = 1'b1; repeat (150) @(negedge clk);
    check(pulses == start + 1, "R8 short release ignored", pulses - start, 1);
    check(col_o == 4'b0010, "R8 column parked", col_o, 2);
    pressed = 1'b0;
    repeat (20) @(negedge clk);
    check(col_o == 4'b0010, "R9 resumes same column", col_o, 2);
    prev = col_o;
    for (int i = 0; i < 100 && col_o == prev; i++) @(negedge clk);
    check(col_o == 4'b0100, "R9 next column", col_o, 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule